// File: doc/BRIEF.md
# BCD Clock Calendar Counter Chain

This block keeps the time of day and the calendar date in packed BCD: seconds, minutes, hours (24-hour form), a weekday counter, day of month, month, a two-digit year and a century bit. A single-cycle strobe arriving 64 times per second feeds a 6-bit prescaler. The prescaler turns those strobes into one-second increments, and each field carries into the next as it wraps. The last day of each month follows the month length, with a leap February in every year divisible by four.

Software loads any field through a synchronous write port and reads any field through a combinational read port. A stop input freezes the chain and clears the prescaler. When the stop is released, the first second arrives after half a prescaler period. A sticky flag records that the oscillator failed. The flag is set by a fail input and cleared only by a write.

Top module: `rtc_cal_chain`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hours 00, weekday 0, date 01, month 01, year 00 and century 0, and the oscillator-fail flag reads 1.
- R2: Seconds and minutes count in BCD from 00 to 59 and carry into the next field when they wrap to 00. Hours count 00 to 23.
- R3: The hour wrap from 23 to 00 advances both the date and the weekday. The weekday counts 0 to 6 and then returns to 0.
- R4: The last date is 31 for months 01, 03, 05, 07, 08, 10 and 12, and 30 for months 04, 06, 09 and 11. February ends at 29 when the BCD year is divisible by 4 (00 included) and at 28 otherwise. After the last date the date returns to 01 and the month advances.
- R5: The month counts 01 to 12 and carries into the year. The year counts 00 to 99. The century bit, read at bit 7 of address 5, toggles each time the year wraps from 99 to 00.
- R6: The seconds field advances once every 64 strobes. Out of reset, or after the stop input is released, the first advance comes on the 32nd strobe.
- R7: While the stop input is 1, strobes are ignored, the prescaler is held at zero and no field advances.
- R8: The oscillator-fail flag (bit 7 of address 0) is set by a one-cycle high on the fail input and stays 1 until a write to address 0 with bit 7 equal to 0.
- R9: A write to a field in the same cycle as an increment of that field wins, and that field then sends no carry onward. Writes do not disturb the prescaler phase.
- R10: A field loaded with an illegal BCD value still returns to its legal range on its next increment. A value at or above the field's last value wraps to the field's first value. A low digit of 9 or more clears to 0 and raises the high digit.
- R11: The address map is 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month, 6 year, and address 7 reads 00. Writes keep only the low 7, 7, 6, 3, 6, 5 and 8 bits of these fields, and bits that are not kept read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick64_i | input | 1 | One-cycle strobe, 64 per second |
| stop_i | input | 1 | Freeze the chain and clear the prescaler |
| osc_fail_i | input | 1 | Oscillator failure indication |
| wr_en_i | input | 1 | Field write enable |
| wr_addr_i | input | 3 | Field write address |
| wr_data_i | input | 8 | Field write data |
| rd_addr_i | input | 3 | Field read address |
| rd_data_o | output | 8 | Read data for rd_addr_i |

## Verification
The hardest situation to reach is a strobe that falls in exactly the cycle a software write hits the same field. The strobe must also be the one that completes a second, which only happens at one prescaler phase. The stimulus counts strobes from a known phase (reset or stop release gives 32, each completed second gives 64 more) and places a combined strobe and write on the 64th. The month-end and leap-year cases are reached by loading 23:59:59 on a chosen date and applying one full second.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int FIELD_W    = 8;
  localparam int NUM_FIELDS = 7;

  localparam int IDX_SEC   = 0;
  localparam int IDX_MIN   = 1;
  localparam int IDX_HOUR  = 2;
  localparam int IDX_WDAY  = 3;
  localparam int IDX_DATE  = 4;
  localparam int IDX_MONTH = 5;
  localparam int IDX_YEAR  = 6;

  // BCD increment; an out-of-range low digit clears and carries
  function automatic logic [FIELD_W-1:0] bcd_step(input logic [FIELD_W-1:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [FIELD_W-1:0] field_last(input int idx);
    case (idx)
      IDX_SEC, IDX_MIN: return 8'h59;
      IDX_HOUR:         return 8'h23;
      IDX_WDAY:         return 8'h06;
      IDX_MONTH:        return 8'h12;
      IDX_YEAR:         return 8'h99;
      default:          return 8'h31;
    endcase
  endfunction

  function automatic logic [FIELD_W-1:0] field_first(input int idx);
    return (idx == IDX_DATE || idx == IDX_MONTH) ? 8'h01 : 8'h00;
  endfunction

  function automatic logic [FIELD_W-1:0] field_mask(input int idx);
    case (idx)
      IDX_SEC, IDX_MIN:   return 8'h7F;
      IDX_HOUR, IDX_DATE: return 8'h3F;
      IDX_WDAY:           return 8'h07;
      IDX_MONTH:          return 8'h1F;
      default:            return 8'hFF;
    endcase
  endfunction

  // Year in BCD divisible by four
  function automatic logic bcd_leap(input logic [FIELD_W-1:0] y);
    if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    else       return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

  function automatic logic [FIELD_W-1:0] month_end(input logic [FIELD_W-1:0] mon,
                                                   input logic [FIELD_W-1:0] yr);
    case (mon)
      8'h02:                      return bcd_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe_i,
  input  logic             stop_i,
  output logic             sec_tick_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] FIRE_AT = CNT_W'((1 << (CNT_W - 1)) - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d      = cnt_q;
    sec_tick_o = 1'b0;
    if (stop_i) begin
      cnt_d = '0;
    end else if (strobe_i) begin
      cnt_d      = cnt_q + 1'b1;
      sec_tick_o = (cnt_q == FIRE_AT);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
  import rtc_cal_pkg::*;
#(
  parameter logic [FIELD_W-1:0] FIRST_VAL = '0,
  parameter logic [FIELD_W-1:0] MASK      = '1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inc_i,
  input  logic [FIELD_W-1:0] last_i,
  input  logic               wr_i,
  input  logic [FIELD_W-1:0] wr_data_i,
  output logic [FIELD_W-1:0] value_o,
  output logic               at_last_o
);
  logic [FIELD_W-1:0] val_q, val_d;

  assign at_last_o = (val_q >= last_i);

  always_comb begin
    val_d = val_q;
    if (wr_i)       val_d = wr_data_i & MASK;
    else if (inc_i) val_d = at_last_o ? FIRST_VAL : (bcd_step(val_q) & MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= FIRST_VAL;
    else        val_q <= val_d;
  end

  assign value_o = val_q;
endmodule

// File: rtl/rtc_cal_chain.sv
module rtc_cal_chain
  import rtc_cal_pkg::*;
#(
  parameter int PRESC_W = 6,
  parameter int ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick64_i,
  input  logic               stop_i,
  input  logic               osc_fail_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [FIELD_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [FIELD_W-1:0] rd_data_o
);
  logic               sec_tick;
  logic [PRESC_W-1:0] presc_cnt;
  logic [FIELD_W-1:0] fval     [NUM_FIELDS];
  logic [FIELD_W-1:0] fld_last [NUM_FIELDS];
  logic               at_last  [NUM_FIELDS];
  logic               fld_wr   [NUM_FIELDS];
  logic               fld_inc  [NUM_FIELDS];
  logic               carry    [NUM_FIELDS];
  logic               osc_flag_q, osc_flag_d;
  logic               century_q, century_d;

  rtc_prescaler #(.CNT_W(PRESC_W)) u_presc (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe_i   (tick64_i),
    .stop_i     (stop_i),
    .sec_tick_o (sec_tick),
    .count_o    (presc_cnt)
  );

  // Write decode, limits and the carry chain
  always_comb begin
    for (int i = 0; i < NUM_FIELDS; i++) begin
      fld_wr[i]   = wr_en_i && (wr_addr_i == ADDR_W'(i));
      fld_last[i] = field_last(i);
    end
    fld_last[IDX_DATE] = month_end(fval[IDX_MONTH], fval[IDX_YEAR]);

    fld_inc[IDX_SEC]   = sec_tick;
    carry[IDX_SEC]     = fld_inc[IDX_SEC]   & at_last[IDX_SEC]   & ~fld_wr[IDX_SEC];
    fld_inc[IDX_MIN]   = carry[IDX_SEC];
    carry[IDX_MIN]     = fld_inc[IDX_MIN]   & at_last[IDX_MIN]   & ~fld_wr[IDX_MIN];
    fld_inc[IDX_HOUR]  = carry[IDX_MIN];
    carry[IDX_HOUR]    = fld_inc[IDX_HOUR]  & at_last[IDX_HOUR]  & ~fld_wr[IDX_HOUR];
    fld_inc[IDX_WDAY]  = carry[IDX_HOUR];
    carry[IDX_WDAY]    = 1'b0;
    fld_inc[IDX_DATE]  = carry[IDX_HOUR];
    carry[IDX_DATE]    = fld_inc[IDX_DATE]  & at_last[IDX_DATE]  & ~fld_wr[IDX_DATE];
    fld_inc[IDX_MONTH] = carry[IDX_DATE];
    carry[IDX_MONTH]   = fld_inc[IDX_MONTH] & at_last[IDX_MONTH] & ~fld_wr[IDX_MONTH];
    fld_inc[IDX_YEAR]  = carry[IDX_MONTH];
    carry[IDX_YEAR]    = fld_inc[IDX_YEAR]  & at_last[IDX_YEAR]  & ~fld_wr[IDX_YEAR];
  end

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    rtc_bcd_field #(
      .FIRST_VAL (field_first(g)),
      .MASK      (field_mask(g))
    ) u_field (
      .clk       (clk),
      .rst_n     (rst_n),
      .inc_i     (fld_inc[g]),
      .last_i    (fld_last[g]),
      .wr_i      (fld_wr[g]),
      .wr_data_i (wr_data_i),
      .value_o   (fval[g]),
      .at_last_o (at_last[g])
    );
  end

  // Sticky fail flag and century bit
  always_comb begin
    osc_flag_d = osc_flag_q;
    if (osc_fail_i)           osc_flag_d = 1'b1;
    else if (fld_wr[IDX_SEC]) osc_flag_d = wr_data_i[7];

    century_d = century_q;
    if (fld_wr[IDX_MONTH])    century_d = wr_data_i[7];
    else if (carry[IDX_YEAR]) century_d = ~century_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_flag_q <= 1'b1;
      century_q  <= 1'b0;
    end else begin
      osc_flag_q <= osc_flag_d;
      century_q  <= century_d;
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      ADDR_W'(IDX_SEC):   rd_data_o = {osc_flag_q, fval[IDX_SEC][6:0]};
      ADDR_W'(IDX_MIN):   rd_data_o = fval[IDX_MIN];
      ADDR_W'(IDX_HOUR):  rd_data_o = fval[IDX_HOUR];
      ADDR_W'(IDX_WDAY):  rd_data_o = fval[IDX_WDAY];
      ADDR_W'(IDX_DATE):  rd_data_o = fval[IDX_DATE];
      ADDR_W'(IDX_MONTH): rd_data_o = {century_q, fval[IDX_MONTH][6:0]};
      ADDR_W'(IDX_YEAR):  rd_data_o = fval[IDX_YEAR];
      default:            rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/rtc_cal_chk.sv
module rtc_cal_chk #(
  parameter int PRESC_W = 6,
  parameter int ADDR_W  = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               stop_i,
  input logic               osc_fail_i,
  input logic               wr_en_i,
  input logic [ADDR_W-1:0]  wr_addr_i,
  input logic               sec_tick,
  input logic               year_inc,
  input logic [PRESC_W-1:0] presc_cnt,
  input logic [7:0]         sec_q,
  input logic [7:0]         min_q,
  input logic [7:0]         hour_q,
  input logic [7:0]         wday_q,
  input logic [7:0]         year_q,
  input logic               century_q,
  input logic               osc_flag_q
);
  logic wr_sec, wr_wday, wr_cal;
  assign wr_sec  = wr_en_i && (wr_addr_i == ADDR_W'(0));
  assign wr_wday = wr_en_i && (wr_addr_i == ADDR_W'(3));
  assign wr_cal  = wr_en_i && (wr_addr_i == ADDR_W'(5) || wr_addr_i == ADDR_W'(6));

  // R7
  stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !wr_en_i) |=> $stable({sec_q, min_q, hour_q}));

  // R7
  stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (presc_cnt == '0));

  // R8
  osc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    osc_fail_i |=> osc_flag_q);

  // R8
  osc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_flag_q && !wr_sec) |=> osc_flag_q);

  // R2
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && sec_q == 8'h59 && !wr_sec) |=> (sec_q == 8'h00));

  // R3
  wday_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wday_q <= 8'h06 && !wr_wday) |=> (wday_q <= 8'h06));

  // R5
  century_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (year_inc && year_q == 8'h99 && !wr_cal) |=> (century_q != $past(century_q)));
endmodule

bind rtc_cal_chain rtc_cal_chk #(.PRESC_W(PRESC_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .stop_i     (stop_i),
  .osc_fail_i (osc_fail_i),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .sec_tick   (sec_tick),
  .year_inc   (fld_inc[6]),
  .presc_cnt  (presc_cnt),
  .sec_q      (fval[0]),
  .min_q      (fval[1]),
  .hour_q     (fval[2]),
  .wday_q     (fval[3]),
  .year_q     (fval[6]),
  .century_q  (century_q),
  .osc_flag_q (osc_flag_q)
);

// File: tb/test_rtc_cal_chain.sv
module test_rtc_cal_chain;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick64 = 1'b0;
  logic       stop = 1'b0;
  logic       osc_fail = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;

  int n_vec = 0, n_bad = 0, n_push = 0, n_done = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [2:0] addr;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;

  rtc_cal_chain i_rtc_cal_chain (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick64_i   (tick64),
    .stop_i     (stop),
    .osc_fail_i (osc_fail),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .rd_addr_i  (rd_addr),
    .rd_data_o  (rd_data)
  );

  // Monitor: pops expected items and compares them away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        rd_addr = it.addr;
        #1;
        n_vec++;
        if (rd_data !== it.exp) begin
          n_bad++;
          $display("FAIL %s addr %0d actual %h expected %h", it.tag, it.addr, rd_data, it.exp);
        end
        n_done++;
      end
    end
  end

  task automatic expect_val(input logic [2:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.addr = a; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    n_push++;
    wait (n_done == n_push);
  endtask

  task automatic pulse(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) tick64 = 1'b1;
      @(negedge clk) tick64 = 1'b0;
    end
  endtask

  task automatic one_second();
    pulse(64);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_with_tick(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; tick64 = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick64 = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                          input logic [7:0] w, input logic [7:0] dt, input logic [7:0] mo,
                          input logic [7:0] y);
    wr(3'd0, s); wr(3'd1, m); wr(3'd2, h); wr(3'd3, w);
    wr(3'd4, dt); wr(3'd5, mo); wr(3'd6, y);
  endtask

  // R4: last second of a day, check the new date and month
  task automatic day_end(input logic [7:0] mo, input logic [7:0] y, input logic [7:0] dt,
                         input logic [7:0] e_dt, input logic [7:0] e_mo);
    set_time(8'h59, 8'h59, 8'h23, 8'h03, dt, mo, y);
    one_second();
    expect_val(3'd4, e_dt, "R4 date");
    expect_val(3'd5, e_mo, "R4 month");
    expect_val(3'd3, 8'h04, "R3 weekday step");
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state (fail flag at bit 7 of address 0)
    expect_val(3'd0, 8'h80, "R1 sec and flag");
    expect_val(3'd2, 8'h00, "R1 hour");
    expect_val(3'd3, 8'h00, "R1 weekday");
    expect_val(3'd4, 8'h01, "R1 date");
    expect_val(3'd5, 8'h01, "R1 month");
    expect_val(3'd6, 8'h00, "R1 year");

    // R8 clear by write, R6 prescaler phase from reset
    wr(3'd0, 8'h00);
    expect_val(3'd0, 8'h00, "R8 flag cleared");
    pulse(31);
    expect_val(3'd0, 8'h00, "R6 before 32nd strobe");
    pulse(1);
    expect_val(3'd0, 8'h01, "R6 at 32nd strobe");
    pulse(63);
    expect_val(3'd0, 8'h01, "R6 before 64th strobe");
    pulse(1);
    expect_val(3'd0, 8'h02, "R6 at 64th strobe");

    // R2 R3 R5 full rollover
    set_time(8'h59, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12, 8'h99);
    one_second();
    expect_val(3'd0, 8'h00, "R2 sec wrap");
    expect_val(3'd1, 8'h00, "R2 min wrap");
    expect_val(3'd2, 8'h00, "R2 hour wrap");
    expect_val(3'd3, 8'h00, "R3 weekday wrap");
    expect_val(3'd4, 8'h01, "R4 date wrap");
    expect_val(3'd5, 8'h81, "R5 month wrap and century");
    expect_val(3'd6, 8'h00, "R5 year wrap");

    // R2 plain minute carry
    set_time(8'h59, 8'h09, 8'h10, 8'h01, 8'h05, 8'h05, 8'h05);
    one_second();
    expect_val(3'd1, 8'h10, "R2 min BCD carry");
    expect_val(3'd2, 8'h10, "R2 hour hold");

    // R4 month lengths and leap rule
    day_end(8'h02, 8'h24, 8'h28, 8'h29, 8'h02);
    day_end(8'h02, 8'h24, 8'h29, 8'h01, 8'h03);
    day_end(8'h02, 8'h23, 8'h28, 8'h01, 8'h03);
    day_end(8'h02, 8'h00, 8'h28, 8'h29, 8'h02);
    day_end(8'h02, 8'h10, 8'h28, 8'h01, 8'h03);
    day_end(8'h02, 8'h12, 8'h28, 8'h29, 8'h02);
    day_end(8'h04, 8'h05, 8'h30, 8'h01, 8'h05);
    day_end(8'h01, 8'h05, 8'h30, 8'h31, 8'h01);
    day_end(8'h08, 8'h05, 8'h31, 8'h01, 8'h09);
    day_end(8'h11, 8'h05, 8'h30, 8'h01, 8'h12);

    // R7 stop holds, R6 half period after release
    wr(3'd0, 8'h10);
    @(negedge clk) stop = 1'b1;
    pulse(100);
    expect_val(3'd0, 8'h10, "R7 frozen while stopped");
    @(negedge clk) stop = 1'b0;
    pulse(31);
    expect_val(3'd0, 8'h10, "R6 after release before 32");
    pulse(1);
    expect_val(3'd0, 8'h11, "R6 after release at 32");

    // R9 write wins over increment, no carry; prescaler phase kept
    wr(3'd0, 8'h59);
    wr(3'd1, 8'h20);
    pulse(63);
    expect_val(3'd0, 8'h59, "R9 before collision");
    wr_with_tick(3'd0, 8'h30);
    expect_val(3'd0, 8'h30, "R9 write wins");
    expect_val(3'd1, 8'h20, "R9 no carry");
    pulse(40);
    wr(3'd2, 8'h05);
    pulse(23);
    expect_val(3'd0, 8'h30, "R9 phase kept before");
    pulse(1);
    expect_val(3'd0, 8'h31, "R9 phase kept at 64");

    // R10 illegal values return to range
    wr(3'd0, 8'h7F);
    wr(3'd1, 8'h5A);
    wr(3'd2, 8'h1C);
    one_second();
    expect_val(3'd0, 8'h00, "R10 sec wraps");
    expect_val(3'd1, 8'h00, "R10 min wraps");
    expect_val(3'd2, 8'h20, "R10 hour digit fix");

    // R8 sticky flag
    @(negedge clk) osc_fail = 1'b1;
    @(negedge clk) osc_fail = 1'b0;
    expect_val(3'd0, 8'h80, "R8 flag set");
    one_second();
    expect_val(3'd0, 8'h81, "R8 flag sticky");
    wr(3'd0, 8'h00);
    expect_val(3'd0, 8'h00, "R8 flag cleared by write");

    // R11 masks and unused address
    wr(3'd3, 8'hFF);
    expect_val(3'd3, 8'h07, "R11 weekday mask");
    wr(3'd5, 8'hFF);
    expect_val(3'd5, 8'h9F, "R11 month mask");
    wr(3'd2, 8'hFF);
    expect_val(3'd2, 8'h3F, "R11 hour mask");
    expect_val(3'd7, 8'h00, "R11 unused address");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule